// File: doc/BRIEF.md
# Power-Fail Retentive Set/Reset Latch

This block is a set/reset memory cell that keeps its state across a loss of supply. It takes two request lines, one to switch on and one to switch off, and a power-good line. It drives a complementary pair of outputs. A request moves the outputs after a short, fixed latency. A separate slow path writes a retained bit, but only after the same request has stayed active for a much longer hold. Short or bouncing requests therefore move the outputs and are forgotten at the next supply loss.

While power-good is low, the outputs are dark and every request in flight is dropped. The retained bit is frozen during that time. When power returns, the outputs show the retained bit straight away. A static parameter selects which request wins when both are active. The default gives priority to switching off. The other setting gives priority to switching on.

Top module: `retain_latch`

## Requirements
- R1: After reset, the retained bit is OFF. With power-good high, out_on is 0 and out_off is 1.
- R2: A resolved request sampled at clock edge k sets the output state at edge k+FAST_CYC (ON gives out_on=1, OFF gives out_off=1). With no request active, the output state holds.
- R3: A request pulse of any length moves the outputs for the same number of cycles, FAST_CYC edges later. A bouncing input therefore shows as matching output pulses.
- R4: The retained bit takes the value of a resolved request on the edge where that request has been sampled on HOLD_CYC consecutive edges. A run that ends after HOLD_CYC-1 samples leaves the retained bit unchanged.
- R5: The hold run restarts when the resolved request drops to none or changes to the other value. This includes the case where the opposing line rises and wins priority.
- R6: With OFF_WINS=1, two simultaneous requests resolve to OFF (out_on=0, out_off=1).
- R7: With OFF_WINS=0, two simultaneous requests resolve to ON (out_on=1, out_off=0).
- R8: While pwr_ok is 0, both outputs are 0, requests are ignored, the pending pipeline and hold run are cleared, and the retained bit keeps its value.
- R9: In the first cycle that pwr_ok is high again, the outputs show the retained bit, and requests sampled on that edge are ignored.
- R10: Whenever pwr_ok is 1, out_on and out_off are exact complements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply good; low means supply lost |
| req_on | input | 1 | Request to switch on |
| req_off | input | 1 | Request to switch off |
| out_on | output | 1 | ON-side output |
| out_off | output | 1 | OFF-side output |

## Verification
On every cycle, the embedded assertions check the following:
- the retained bit stays frozen and the hold run is cleared while supply is low;
- the retained bit only ever changes at the end of a full hold run;
- the outputs are dark while power is down;
- the outputs come back from the retained bit in the first powered cycle.

Whether a given pulse was too short to be remembered, how bounce is echoed, and how the two priority settings resolve a conflict can only be shown by the bench. It runs directed and random request patterns, each followed by a supply cycle that exposes the retained bit at the ports.

// File: rtl/retain_pkg.sv
package retain_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } cmd_e;
endpackage

// File: rtl/rl_resolve.sv
module rl_resolve
    import retain_pkg::*;
#(
    parameter bit OFF_WINS = 1'b1
) (
    input  logic req_on,
    input  logic req_off,
    input  logic gate,
    output cmd_e cmd
);
    cmd_e conflict_win;

    generate
        if (OFF_WINS) begin : g_off_pri
            assign conflict_win = CMD_OFF;
        end else begin : g_on_pri
            assign conflict_win = CMD_ON;
        end
    endgenerate

    always_comb begin
        cmd = CMD_NONE;
        if (gate) begin
            if (req_on && req_off) cmd = conflict_win;
            else if (req_on)       cmd = CMD_ON;
            else if (req_off)      cmd = CMD_OFF;
        end
    end
endmodule

// File: rtl/rl_hold.sv
module rl_hold
    import retain_pkg::*;
#(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  cmd_e cmd,
    output logic ret_on
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        cmd_e          prev;
        logic [CW-1:0] cnt;
        logic          ret;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!pwr_ok) begin
            h_d.prev = CMD_NONE;
            h_d.cnt  = '0;
        end else begin
            h_d.prev = cmd;
            if (cmd == CMD_NONE) begin
                h_d.cnt = '0;
            end else if (cmd != h_q.prev) begin
                h_d.cnt = CW'(1);
            end else if (h_q.cnt < CW'(HOLD_CYC)) begin
                h_d.cnt = h_q.cnt + CW'(1);
                if (h_q.cnt == CW'(HOLD_CYC - 1)) h_d.ret = (cmd == CMD_ON);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.prev <= CMD_NONE;
            h_q.cnt  <= '0;
            h_q.ret  <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign ret_on = h_q.ret;

    // R8: retained bit frozen while supply is down
    a_r8_ret_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> h_q.ret == $past(h_q.ret));
    // R8: hold run cleared while supply is down
    a_r8_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> h_q.cnt == '0);
    // R4: retained bit only changes at the end of a full run
    a_r4_commit_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.ret != $past(h_q.ret)) |-> ($past(h_q.cnt) == CW'(HOLD_CYC - 1)));
endmodule

// File: rtl/rl_fast.sv
module rl_fast
    import retain_pkg::*;
#(
    parameter int FAST_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  cmd_e cmd,
    input  logic ret_on,
    output logic state_on
);
    typedef struct packed {
        logic [FAST_CYC-1:0][1:0] pipe;
        logic                     state;
    } fast_t;

    fast_t f_d, f_q;
    cmd_e  tail;

    assign tail = cmd_e'(f_q.pipe[FAST_CYC-1]);

    always_comb begin
        f_d = f_q;
        if (!pwr_ok) begin
            f_d.pipe  = '0;
            f_d.state = ret_on;
        end else begin
            if (tail != CMD_NONE) f_d.state = (tail == CMD_ON);
            f_d.pipe[0] = cmd;
            for (int i = 1; i < FAST_CYC; i++) f_d.pipe[i] = f_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.pipe  <= '0;
            f_q.state <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state_on = f_q.state;

    // R8: output state tracks the retained bit while supply is down
    a_r8_state_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> f_q.state == $past(ret_on));
endmodule

// File: rtl/retain_latch.sv
module retain_latch
    import retain_pkg::*;
#(
    parameter int FAST_CYC = 5,
    parameter int HOLD_CYC = 40,
    parameter bit OFF_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic req_on,
    input  logic req_off,
    output logic out_on,
    output logic out_off
);
    typedef struct packed {
        logic pwr;
    } top_t;

    top_t t_d, t_q;
    cmd_e cmd;
    logic ret_on;
    logic state_on;

    always_comb begin
        t_d     = t_q;
        t_d.pwr = pwr_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.pwr <= 1'b0;
        else        t_q <= t_d;
    end

    rl_resolve #(.OFF_WINS(OFF_WINS)) i_resolve (
        .req_on (req_on),
        .req_off(req_off),
        .gate   (pwr_ok & t_q.pwr),
        .cmd    (cmd)
    );

    rl_hold #(.HOLD_CYC(HOLD_CYC)) i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_ok(pwr_ok),
        .cmd   (cmd),
        .ret_on(ret_on)
    );

    rl_fast #(.FAST_CYC(FAST_CYC)) i_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_ok  (pwr_ok),
        .cmd     (cmd),
        .ret_on  (ret_on),
        .state_on(state_on)
    );

    assign out_on  = pwr_ok & state_on;
    assign out_off = pwr_ok & ~state_on;

    // R8: outputs dark while supply is down
    a_r8_outputs_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (!out_on && !out_off));
    // R9: first powered cycle shows the retained bit
    a_r9_restore_from_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !t_q.pwr) |-> (out_on == ret_on));
endmodule

// File: tb/test_retain_latch.sv
module test_retain_latch;
    localparam int CLK_PER = 10;
    localparam int FAST = 3;
    localparam int HOLD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic req_on = 1'b0;
    logic req_off = 1'b0;
    logic on_a, off_a, on_b, off_b;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    retain_latch #(.FAST_CYC(FAST), .HOLD_CYC(HOLD), .OFF_WINS(1'b1)) i_retain_latch (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req_on(req_on), .req_off(req_off),
        .out_on(on_a), .out_off(off_a));

    retain_latch #(.FAST_CYC(FAST), .HOLD_CYC(HOLD), .OFF_WINS(1'b0)) i_retain_latch_on (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req_on(req_on), .req_off(req_off),
        .out_on(on_b), .out_off(off_b));

    // reference: index 0 = off-priority, 1 = on-priority; cmd 0 none, 1 on, 2 off
    int  m_pipe [2][FAST];
    bit  m_state [2];
    bit  m_ret [2];
    int  m_run [2];
    int  m_last [2];
    bit  m_pq;

    function automatic int pick(bit on, bit off, bit on_pri);
        if (on && off) return on_pri ? 1 : 2;
        if (on) return 1;
        if (off) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < 2; v++) begin
                for (int i = 0; i < FAST; i++) m_pipe[v][i] = 0;
                m_state[v] = 1'b0; m_ret[v] = 1'b0; m_run[v] = 0; m_last[v] = 0;
            end
            m_pq = 1'b0;
        end else begin
            for (int v = 0; v < 2; v++) begin
                int c;
                c = (pwr_ok && m_pq) ? pick(req_on, req_off, v == 1) : 0;
                if (!pwr_ok) begin
                    for (int i = 0; i < FAST; i++) m_pipe[v][i] = 0;
                    m_state[v] = m_ret[v];
                    m_run[v] = 0; m_last[v] = 0;
                end else begin
                    if (m_pipe[v][FAST-1] != 0) m_state[v] = (m_pipe[v][FAST-1] == 1);
                    for (int i = FAST-1; i > 0; i--) m_pipe[v][i] = m_pipe[v][i-1];
                    m_pipe[v][0] = c;
                    if (c == 0) m_run[v] = 0;
                    else if (c != m_last[v]) m_run[v] = 1;
                    else if (m_run[v] < HOLD) begin
                        m_run[v] = m_run[v] + 1;
                        if (m_run[v] == HOLD) m_ret[v] = (c == 1);
                    end
                    m_last[v] = c;
                end
            end
            m_pq = pwr_ok;
        end
    end

    task automatic cmp(string t, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #(CLK_PER/4);
        if (rst_n && !done) begin
            cmp(tag, on_a,  pwr_ok & m_state[0],  "off-pri out_on");
            cmp(tag, off_a, pwr_ok & ~m_state[0], "off-pri out_off");
            cmp(tag, on_b,  pwr_ok & m_state[1],  "on-pri out_on");
            cmp(tag, off_b, pwr_ok & ~m_state[1], "on-pri out_off");
            if (pwr_ok) begin
                cmp("R10", on_a ^ off_a, 1'b1, "off-pri complement");
                cmp("R10", on_b ^ off_b, 1'b1, "on-pri complement");
            end
        end
    end

    task automatic drive(bit on, bit off, int n);
        req_on = on; req_off = off;
        repeat (n) @(negedge clk);
    endtask

    task automatic power_cycle(int down);
        pwr_ok = 1'b0;
        repeat (down) @(negedge clk);
        pwr_ok = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        rst_n = 1'b1; pwr_ok = 1'b1;
        tag = "R1"; drive(0, 0, 4);
        // explicit reset value check
        cmp("R1", off_a, 1'b1, "reset out_off");
        cmp("R1", on_a, 1'b0, "reset out_on");

        tag = "R2"; drive(1, 0, 4); drive(0, 0, 6);
        tag = "R4"; power_cycle(3); drive(0, 0, 3);   // short ON forgotten
        tag = "R4"; drive(1, 0, HOLD - 1); drive(0, 0, 5); power_cycle(2);
        tag = "R4"; drive(1, 0, HOLD); drive(0, 0, 5); power_cycle(2); drive(0, 0, 3);
        tag = "R3";
        for (int k = 0; k < 6; k++) begin
            drive(0, 1, 1 + (k % 2)); drive(0, 0, 1 + (k % 3));
        end
        drive(0, 0, 6); power_cycle(2);
        tag = "R5"; drive(0, 1, HOLD - 1); drive(0, 0, 1); drive(0, 1, HOLD - 1); drive(0, 0, 5);
        power_cycle(2);
        tag = "R5"; drive(0, 1, HOLD - 2); drive(1, 1, 3); drive(0, 1, HOLD - 2); drive(0, 0, 5);
        power_cycle(2);
        tag = "R6"; drive(1, 1, HOLD + 2); drive(0, 0, 5); power_cycle(2);
        tag = "R7"; drive(1, 0, HOLD + 2); drive(1, 1, HOLD + 2); drive(0, 0, 5); power_cycle(2);
        tag = "R8"; drive(1, 0, 2); pwr_ok = 1'b0; drive(1, 0, HOLD + 3); drive(0, 1, 4);
        tag = "R9"; pwr_ok = 1'b1; drive(1, 1, 1); drive(0, 0, 6);
        tag = "R8"; power_cycle(1);
        tag = "R5";
        for (int s = 0; s < 400; s++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0) begin
                tag = "R8"; pwr_ok = 1'b0;
                drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(1, 4)));
                tag = "R9"; pwr_ok = 1'b1;
                drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1);
            end else begin
                tag = (r < 4) ? "R3" : "R4";
                drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      int'($urandom_range(1, 2 * HOLD)));
            end
        end
        tag = "R9"; drive(0, 0, 6); power_cycle(2);
        finish_run();
    end
endmodule